// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is an SPI slave that sits in front of a small byte-wide array and runs opcode-driven commands on it. It works in clock modes 0 and 3. The bus master selects it with an active-low chip select and shifts in an 8-bit opcode, MSB first. Depending on the opcode, the block then takes a 16-bit address, data bytes or a status byte, or it shifts array or status bytes out on SO. SI, SCK and chip select are sampled in the system clock domain through a short synchronizer. SO changes only after a falling SCK edge, and its enable is low while the block is deselected.

Writes to the array are gathered in a one-page staging buffer. They land in the array only when chip select rises exactly on a byte boundary and the write-enable latch is set. Each landed write starts a busy interval that is counted in system clocks. While that interval runs, the status byte shows write-in-progress. Every command other than the status read is refused, and the write-enable latch clears when the interval ends. A two-bit lock field in the status register fences off the top quarter, the top half or all of the array from writes. A protect-enable bit together with the `wp_n` pin can freeze the status register itself.

FSM states: `ST_IDLE` (deselected), `ST_OPC` (opcode shift-in), `ST_ADDR` (two address bytes), `ST_RDAT` (array bytes out), `ST_WDAT` (write bytes in), `ST_SOUT` (status bytes out), `ST_SIN` (status byte in), `ST_SKIP` (rest of a frame ignored). Transitions: a falling chip select goes from any state to `ST_OPC`. A rising chip select goes from any state to `ST_IDLE`. From `ST_OPC` on the eighth bit, a read or write opcode goes to `ST_ADDR`, the status read to `ST_SOUT`, the status write to `ST_SIN`, and every other opcode, or any refused opcode, to `ST_SKIP`. From `ST_ADDR` on the sixteenth address bit the engine goes to `ST_RDAT` or `ST_WDAT`.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset, `so_oe` and `so` are 0, and the status byte reads 0x00.
- R2: Until chip select has gone from high to low after reset, clocked bits are ignored and `so_oe` stays 0. Sending set-flag (0x00) with chip select already low at reset leaves the flag clear.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) only if chip select rises right after its eighth bit. If any further SCK rising edge comes first, the latch stays clear.
- R4: Opcode 0x00 sets the flag (status bit 4). Opcode 0x04 clears both the flag and the write-enable latch.
- R5: Opcode 0x05 shifts out the status byte repeatedly, MSB first. The layout is bit 7 protect-enable, bits 6:5 timer select, bit 4 flag, bits 3:2 lock level, bit 1 write-enable latch, bit 0 write-in-progress. It may be read during a busy interval, when it shows bits 1 and 0 both set.
- R6: Opcode 0x03 followed by a 16-bit address returns bytes from that address on, whose high unused bits are ignored. The address increments after each byte and wraps from the top address to 0.
- R7: Opcode 0x02 followed by a 16-bit address takes data bytes whose offset wraps inside the 32-byte page. A later byte at the same offset replaces an earlier one, and locations not sent keep their contents.
- R8: A write (array or status) takes effect only when chip select rises after a whole number of data bytes, at least one. Otherwise nothing changes and the write-enable latch keeps its value.
- R9: A write sent while the write-enable latch is clear changes nothing.
- R10: A write that takes effect sets write-in-progress for BUSY_CYCLES system clocks and then clears both bit 0 and bit 1. During that interval every opcode except 0x05 is ignored, and a read returns 0x00.
- R11: Opcode 0x01 with one data byte loads bits 7, 6:5, 4 and 3:2 and ignores data bits 1:0. It is refused when protect-enable is 1 and `wp_n` is 0.
- R12: Lock level 1 protects the top quarter of the array, level 2 the top half and level 3 all of it. Bytes aimed at protected addresses are dropped.
- R13: `so_oe` is 1 only while chip select is low (after a falling edge). Modes 0 and 3 both work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, sampled on SCK rising |
| wp_n | input | 1 | Active-low status write protect pin |
| so | output | 1 | Serial data out, changes after SCK falling |
| so_oe | output | 1 | Output enable for the SO pad driver |

## Verification
The hardest situations to reach from the pins are the ones that must do nothing: a write cut off a few bits into a byte, a latch command padded with one extra clock, and commands sent while a commit is still counting down. The stimulus reaches them with a bit-granular transfer task that ends a frame after any number of bits, and with a long busy interval so that status reads and refused commands can be sent inside it. A frame clocked with chip select already low at reset exercises the arming rule. The page wrap and the top-of-array read wrap are driven by starting transfers two bytes before a boundary.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_SETF  = 8'h00;
    localparam logic [7:0] OP_CLR   = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_SOUT,
        ST_SIN,
        ST_SKIP
    } eng_state_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic si_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_lvl,
    output logic si_lvl
);

    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] si_p;

    // chip select resets low so that only a real high-to-low edge arms the engine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '0;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck_i};
            cs_p  <= {cs_p[STAGES-1:0], cs_n_i};
            si_p  <= {si_p[STAGES-2:0], si_i};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
    assign cs_lvl   = cs_p[STAGES-1];
    assign si_lvl   = si_p[STAGES-1];

endmodule

// File: rtl/spi_mem_pagebuf.sv
module spi_mem_pagebuf #(
    parameter  int PAGE = 32,
    localparam int IW   = $clog2(PAGE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic [7:0]           wr_data,
    output logic [PAGE-1:0][7:0] data_o,
    output logic [PAGE-1:0]      vld_o
);

    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_o[g] <= '0;
                vld_o[g]  <= 1'b0;
            end else if (clear) begin
                vld_o[g]  <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                data_o[g] <= wr_data;
                vld_o[g]  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store #(
    parameter  int ADDR_W = 8,
    parameter  int PAGE   = 32,
    localparam int PG_W   = $clog2(PAGE),
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    input  logic                     commit,
    input  logic [ADDR_W-PG_W-1:0]   page,
    input  logic [PAGE-1:0][7:0]     bytes_i,
    input  logic [PAGE-1:0]          vld_i,
    input  logic [1:0]               lock
);

    logic [7:0] mem [DEPTH];

    function automatic logic fenced(input logic [ADDR_W-1:0] a, input logic [1:0] lv);
        logic r;
        unique case (lv)
            2'd0:    r = 1'b0;
            2'd1:    r = a[ADDR_W-1] & a[ADDR_W-2];
            2'd2:    r = a[ADDR_W-1];
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int j = 0; j < PAGE; j++) begin
                if (vld_i[j] && !fenced({page, PG_W'(j)}, lock))
                    mem[{page, PG_W'(j)}] <= bytes_i[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int CW   = $clog2(BUSY_CYCLES + 1);

    eng_state_e state, nxt;

    logic sck_rise, sck_fall, cs_rise, cs_fall, cs_lvl, si_lvl;
    logic [6:0] sh;
    logic [7:0] out_sh, addr_hi, nbyte, status_byte, rd_data;
    logic [5:0] st_new;
    logic [2:0] bitcnt, ocnt;
    logic       abyte, cmd_rd, pend, extra, got, last_bit, opc_ok;
    logic [ADDR_W-1:0]      rd_ptr, rd_sel, a_full;
    logic [ADDR_W-PG_W-1:0] wr_page;
    logic [PG_W-1:0]        wr_off;
    logic       wpen, flag, wel, wip;
    logic [1:0] tsel, lock;
    logic [CW-1:0] busy_cnt;
    logic       arr_commit, buf_clr, buf_we;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_vld;

    spi_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .cs_lvl(cs_lvl), .si_lvl(si_lvl)
    );

    spi_mem_pagebuf #(.PAGE(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clr), .wr_en(buf_we),
        .wr_idx(wr_off), .wr_data(nbyte), .data_o(buf_data), .vld_o(buf_vld)
    );

    spi_mem_store #(.ADDR_W(ADDR_W), .PAGE(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_sel), .rd_data(rd_data),
        .commit(arr_commit), .page(wr_page), .bytes_i(buf_data),
        .vld_i(buf_vld), .lock(lock)
    );

    assign nbyte       = {sh, si_lvl};
    assign last_bit    = sck_rise && (bitcnt == 3'd7);
    assign opc_ok      = !wip || (nbyte == OP_RDST);
    assign a_full      = ADDR_W'({addr_hi, nbyte});
    assign status_byte = {wpen, tsel, flag, lock, wel, wip};
    assign rd_sel      = (state == ST_ADDR) ? a_full : rd_ptr;
    assign buf_we      = last_bit && (state == ST_WDAT);
    assign buf_clr     = last_bit && (state == ST_ADDR) && abyte && !cmd_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = ST_IDLE;
        end else if (cs_fall) begin
            nxt = ST_OPC;
        end else if (last_bit) begin
            unique case (state)
                ST_OPC: begin
                    if (!opc_ok) begin
                        nxt = ST_SKIP;
                    end else begin
                        unique case (nbyte)
                            OP_READ, OP_WRITE: nxt = ST_ADDR;
                            OP_RDST:           nxt = ST_SOUT;
                            OP_WRST:           nxt = ST_SIN;
                            default:           nxt = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: if (abyte) nxt = cmd_rd ? ST_RDAT : ST_WDAT;
                default: nxt = state;
            endcase
        end
    end

    // datapath, status register and output drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so <= 1'b0; so_oe <= 1'b0;
            sh <= '0; out_sh <= '0; addr_hi <= '0; st_new <= '0;
            bitcnt <= '0; ocnt <= '0;
            abyte <= 1'b0; cmd_rd <= 1'b0; pend <= 1'b0; extra <= 1'b0; got <= 1'b0;
            rd_ptr <= '0; wr_page <= '0; wr_off <= '0;
            wpen <= 1'b0; flag <= 1'b0; wel <= 1'b0; wip <= 1'b0;
            tsel <= '0; lock <= '0; busy_cnt <= '0; arr_commit <= 1'b0;
        end else begin
            arr_commit <= 1'b0;
            if (wip) begin
                busy_cnt <= busy_cnt - CW'(1);
                if (busy_cnt == CW'(1)) begin
                    wip <= 1'b0;
                    wel <= 1'b0;
                end
            end
            if (cs_fall) begin
                so_oe <= 1'b1; so <= 1'b0;
                bitcnt <= '0; abyte <= 1'b0; pend <= 1'b0; extra <= 1'b0; got <= 1'b0;
            end else if (cs_rise) begin
                so_oe <= 1'b0;
                if (state == ST_SKIP && pend && !extra)
                    wel <= 1'b1;
                if (state == ST_WDAT && bitcnt == 3'd0 && got && wel) begin
                    arr_commit <= 1'b1;
                    wip        <= 1'b1;
                    busy_cnt   <= CW'(BUSY_CYCLES);
                end
                if (state == ST_SIN && bitcnt == 3'd0 && got && wel && !(wpen && !wp_n)) begin
                    {wpen, tsel, flag, lock} <= st_new;
                    wip      <= 1'b1;
                    busy_cnt <= CW'(BUSY_CYCLES);
                end
            end else begin
                if (sck_rise) begin
                    if (state inside {ST_OPC, ST_ADDR, ST_WDAT, ST_SIN}) begin
                        sh     <= nbyte[6:0];
                        bitcnt <= bitcnt + 3'd1;
                    end
                    if (state == ST_SKIP) extra <= 1'b1;
                end
                if (last_bit) begin
                    unique case (state)
                        ST_OPC: begin
                            cmd_rd <= (nbyte == OP_READ);
                            if (opc_ok) begin
                                unique case (nbyte)
                                    OP_WEN:  pend <= 1'b1;
                                    OP_CLR:  begin wel <= 1'b0; flag <= 1'b0; end
                                    OP_SETF: flag <= 1'b1;
                                    OP_RDST: begin out_sh <= status_byte; ocnt <= '0; end
                                    default: ;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (!abyte) begin
                                addr_hi <= nbyte;
                                abyte   <= 1'b1;
                            end else if (cmd_rd) begin
                                out_sh <= rd_data;
                                ocnt   <= '0;
                                rd_ptr <= a_full + ADDR_W'(1);
                            end else begin
                                wr_page <= a_full[ADDR_W-1:PG_W];
                                wr_off  <= a_full[PG_W-1:0];
                            end
                        end
                        ST_WDAT: begin
                            wr_off <= wr_off + PG_W'(1);
                            got    <= 1'b1;
                        end
                        ST_SIN: begin
                            st_new <= nbyte[7:2];
                            got    <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && (state == ST_RDAT || state == ST_SOUT)) begin
                    so   <= out_sh[7];
                    ocnt <= ocnt + 3'd1;
                    if (ocnt == 3'd7) begin
                        if (state == ST_RDAT) begin
                            out_sh <= rd_data;
                            rd_ptr <= rd_ptr + ADDR_W'(1);
                        end else begin
                            out_sh <= status_byte;
                        end
                    end else begin
                        out_sh <= {out_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic cs_rise,
    input logic so_oe,
    input logic wel,
    input logic wip,
    input logic arr_commit
);

    // R13
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !so_oe);

    // R3
    wel_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise));

    // R10
    busy_end_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);

    // R10
    commit_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_commit |-> $rose(wip));

    // R9
    busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

endmodule

bind spi_mem_engine spi_mem_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .so_oe(so_oe), .wel(wel), .wip(wip), .arr_commit(arr_commit)
);

// File: tb/tb_spi_mem_engine.sv
module tb_spi_mem_engine;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe;

    always #4 clk = ~clk;

    spi_mem_engine #(.BUSY_CYCLES(2000)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    localparam int HP = 8;
    int total = 0;
    int bad = 0;
    bit cpol = 1'b0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      req_q[$];
    logic [7:0] q[$];
    logic [7:0] r;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer_n(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b0; si = tx[i];
            tick(HP);
            rx[i] = so;
            sck = 1'b1;
            tick(HP);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_n(tx, 8, rx);
    endtask

    task automatic sel();
        sck = cpol; tick(HP);
        cs_n = 1'b0; tick(HP);
    endtask

    task automatic desel();
        if (!cpol) sck = 1'b0;
        tick(HP);
        cs_n = 1'b1; tick(2 * HP);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, d); desel();
    endtask

    task automatic expect_byte(input logic [7:0] e, input string req);
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic rdsr(input logic [7:0] e, input string req);
        logic [7:0] d;
        expect_byte(e, req);
        sel(); xfer(8'h05, d); xfer(8'h00, d); got_q.push_back(d); desel();
    endtask

    task automatic read_seq(input logic [15:0] a, input logic [7:0] ev[$], input string req);
        logic [7:0] d;
        sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
        foreach (ev[k]) begin
            expect_byte(ev[k], req);
            xfer(8'h00, d);
            got_q.push_back(d);
        end
        desel();
    endtask

    task automatic write_seq(input logic [15:0] a, input logic [7:0] dv[$], input int tail);
        logic [7:0] d;
        sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
        foreach (dv[k]) xfer(dv[k], d);
        if (tail > 0) xfer_n(8'hFF, tail, d);
        desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, d); xfer(v, d); desel();
    endtask

    task automatic poll_ready();
        logic [7:0] d;
        for (int k = 0; k < 40; k++) begin
            sel(); xfer(8'h05, d); xfer(8'h00, d); desel();
            if (!d[0]) return;
        end
        check(1'b0, "R10 busy never ended", d, 8'h00);
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0] a, e;
        string rq;
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                a = got_q.pop_front();
                e = exp_q.pop_front();
                rq = req_q.pop_front();
                check(a === e, rq, a, e);
            end
        end
    end

    // watchdog
    initial begin
        tick(190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(4);
        check(so_oe === 1'b0 && so === 1'b0, "R1 pins after reset", {6'd0, so_oe, so}, 8'h00);
        // chip select already low at reset: set-flag must be ignored
        xfer(8'h00, r);
        check(so_oe === 1'b0, "R2 so_oe while unarmed", {7'd0, so_oe}, 8'h00);
        sck = 1'b0; tick(HP); cs_n = 1'b1; tick(2 * HP);
        rdsr(8'h00, "R2 flag after unarmed frame");
        sel();
        check(so_oe === 1'b1, "R13 so_oe while selected", {7'd0, so_oe}, 8'h01);
        desel();
        check(so_oe === 1'b0, "R13 so_oe after deselect", {7'd0, so_oe}, 8'h00);

        cmd(8'h00); rdsr(8'h10, "R4 set flag");
        cmd(8'h04); rdsr(8'h00, "R4 clear flag");

        sel(); xfer(8'h06, r); xfer_n(8'h00, 1, r); desel();
        rdsr(8'h00, "R3 enable with extra clock");
        cmd(8'h06); rdsr(8'h02, "R3 enable latch set");
        cmd(8'h04); rdsr(8'h00, "R4 clear latch");

        q = '{8'hAA}; write_seq(16'h0010, q, 0);
        q = '{8'hFF}; read_seq(16'h0010, q, "R9 write without latch");

        cmd(8'h06);
        q = '{8'h11, 8'h22, 8'h33, 8'h44}; write_seq(16'h001E, q, 0);
        rdsr(8'h03, "R5 status during busy");
        q = '{8'h00}; read_seq(16'h001E, q, "R10 read refused while busy");
        poll_ready();
        rdsr(8'h00, "R10 latch cleared after busy");
        q = '{8'h11, 8'h22, 8'hFF, 8'hFF}; read_seq(16'h001E, q, "R7 page wrap tail");
        q = '{8'h33, 8'h44}; read_seq(16'h0000, q, "R7 page wrap head");

        cmd(8'h06);
        q.delete();
        for (int i = 0; i < 32; i++) q.push_back(8'h80 + 8'(i));
        q.push_back(8'hA0); q.push_back(8'hA1);
        write_seq(16'h0040, q, 0);
        poll_ready();
        q = '{8'hA0, 8'hA1, 8'h82}; read_seq(16'h0040, q, "R7 overwrite in page");
        q = '{8'h9F, 8'hFF}; read_seq(16'h005F, q, "R7 page end");

        cmd(8'h06);
        q = '{8'h5A}; write_seq(16'h00FF, q, 0);
        poll_ready();
        q = '{8'hFF, 8'h5A, 8'h33, 8'h44}; read_seq(16'hAAFE, q, "R6 read wraps at top");

        cmd(8'h06);
        q = '{8'h77}; write_seq(16'h0010, q, 3);
        rdsr(8'h02, "R8 partial byte no commit");
        q = '{8'hFF}; read_seq(16'h0010, q, "R8 array unchanged");
        cmd(8'h04);

        cpol = 1'b1;
        rdsr(8'h00, "R13 mode 3 status");
        cmd(8'h06);
        q = '{8'hC3}; write_seq(16'h0030, q, 0);
        poll_ready();
        q = '{8'hC3}; read_seq(16'h0030, q, "R13 mode 3 write and read");
        cpol = 1'b0;

        cmd(8'h06); wrsr(8'h07); poll_ready();
        rdsr(8'h04, "R11 status write ignores low bits");
        cmd(8'h06);
        q = '{8'h12}; write_seq(16'h00C0, q, 0);
        poll_ready();
        q = '{8'hFF}; read_seq(16'h00C0, q, "R12 top quarter fenced");
        cmd(8'h06);
        q = '{8'h34}; write_seq(16'h00BF, q, 0);
        poll_ready();
        q = '{8'h34}; read_seq(16'h00BF, q, "R12 below fence writable");

        cmd(8'h06); wrsr(8'h84); poll_ready();
        rdsr(8'h84, "R11 protect enable set");
        wp_n = 1'b0;
        cmd(8'h06); wrsr(8'h00);
        rdsr(8'h86, "R11 status write refused by pin");
        wp_n = 1'b1;
        wrsr(8'h00); poll_ready();
        rdsr(8'h00, "R11 status write with pin high");

        cmd(8'h06);
        q = '{8'h66}; write_seq(16'h0050, q, 0);
        cmd(8'h00);
        poll_ready();
        rdsr(8'h00, "R10 set flag refused while busy");
        q = '{8'h66}; read_seq(16'h0050, q, "R10 committed data");

        tick(50);
        if (exp_q.size() != 0)
            check(1'b0, "R5 scoreboard left items", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule